// File: doc/BRIEF.md
# Aligned Sync-Word Detector

This block watches a byte stream carrying a configuration image and decides whether the image holds the synchronisation word. The sync word is the four bytes 0x66, 0x55, 0x99, 0xAA, which is the byte-swapped form of the usual word. The block only looks for it at 32-bit boundaries. It accepts one byte on every cycle in which `in_valid` is high. It has no backpressure. The last byte of an image is marked with `in_last`.

The stream is cut into groups of four bytes, counted from the first byte of the stream. A group matches only when its four bytes equal the sync word, in order, in one aligned group. A pattern that crosses a group boundary does not match. A group that ends the stream with fewer than four bytes is never compared.

One cycle after the marked last byte, the block pulses `done` and reports whether the byte count was a multiple of four. The `found` result stays set until the next stream begins. During partial reconfiguration no sync check is needed, and an input then forces `found` high.

Top module: `sync_word_detector`

## Requirements
- R1: While reset is low, and on the first cycle after it, `found`, `done` and `align_err` are 0 (with `partial_bypass` low).
- R2: `found` goes high on the clock edge that accepts the fourth byte of an aligned group whose bytes are 0x66, 0x55, 0x99, 0xAA at stream offsets 4k, 4k+1, 4k+2 and 4k+3.
- R3: A group holding the same bytes in another order, and a pattern starting at an offset that is not a multiple of 4, never set `found`.
- R4: A final group of 1 to 3 bytes is not compared. Its bytes are also not joined with the bytes of the next stream.
- R5: While `partial_bypass` is high, `found` is high in that same cycle, whatever the stream holds.
- R6: `done` is high for exactly the one cycle after the edge that accepts a byte with `in_last` high. It is low at every other time.
- R7: `align_err` is updated on the same edge as `done`. It becomes 1 when the stream length mod 4 is not 0, and 0 otherwise. It holds that value until the first byte of the next stream is accepted, and is cleared then.
- R8: Once set, `found` stays set through the end of the stream and the idle cycles after it. It is cleared on the edge that accepts the first valid byte after a last-marked byte.
- R9: In cycles with `in_valid` low, the byte position does not advance and no output changes. `in_last` and `in_data` are ignored in such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented this cycle and is consumed at the edge |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | The presented byte is the final byte of the stream |
| partial_bypass | input | 1 | Partial reconfiguration selected: force `found` high |
| found | output | 1 | A sync word was seen at an aligned group in the current or just-ended stream |
| done | output | 1 | One-cycle pulse after the final byte |
| align_err | output | 1 | The stream just ended had a length that is not a multiple of 4 |

## Verification
The main internal risk is the byte-position counter. If it slips by even one byte, every later group is cut at the wrong offset. That shows as a missed sync word on the edge after an aligned pattern, or a false `found` from a pattern that crosses a boundary. It also makes `align_err` wrong at the next `done`. A stale byte register or a start-of-stream flag that is not cleared shows up in a later stream. Either `found` survives past that stream's first byte, or a short tail combines with new bytes into a false match. The reference model is compared on every clock, so each of these faults is caught within one cycle of the edge where it happens.

// File: rtl/sync_det_pkg.sv
`timescale 1ns/1ps
package sync_det_pkg;

  localparam int unsigned DEF_BYTE_W      = 8;
  localparam int unsigned DEF_GROUP_BYTES = 4;
  // lane 0 byte sits in the most significant position
  localparam logic [31:0] DEF_SYNC_WORD   = 32'h665599AA;

  // next byte lane within a group, wrapping at the group size
  function automatic int unsigned lane_step(int unsigned lane, int unsigned group_bytes);
    return (lane + 1 == group_bytes) ? 0 : lane + 1;
  endfunction

  // byte expected at a given lane of the packed sync word
  function automatic int unsigned lane_shift(int unsigned lane, int unsigned group_bytes,
                                             int unsigned byte_w);
    return (group_bytes - 1 - lane) * byte_w;
  endfunction

endpackage

// File: rtl/sync_det_lane.sv
`timescale 1ns/1ps
module sync_det_lane
  import sync_det_pkg::*;
#(
  parameter int unsigned GROUP_BYTES = DEF_GROUP_BYTES,
  localparam int unsigned LANE_W = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  output logic [LANE_W-1:0] lane,
  output logic              group_close,
  output logic              stream_open,
  output logic              tail_ragged
);

  logic [LANE_W-1:0] lane_q;
  logic [LANE_W-1:0] lane_after;
  logic              open_pend_q;

  assign lane_after  = LANE_W'(lane_step(int'(lane_q), GROUP_BYTES));
  assign lane        = lane_q;
  assign group_close = in_valid && (int'(lane_q) == GROUP_BYTES - 1);
  assign stream_open = in_valid && open_pend_q;
  assign tail_ragged = (lane_after != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q      <= '0;
      open_pend_q <= 1'b1;
    end else if (in_valid) begin
      lane_q      <= in_last ? '0 : lane_after;
      open_pend_q <= in_last;
    end
  end

  assert_lane_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lane_q));

  assert_lane_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (lane_q == '0));

endmodule

// File: rtl/sync_det_match.sv
`timescale 1ns/1ps
module sync_det_match
  import sync_det_pkg::*;
#(
  parameter int unsigned BYTE_W      = DEF_BYTE_W,
  parameter int unsigned GROUP_BYTES = DEF_GROUP_BYTES,
  parameter logic [BYTE_W*GROUP_BYTES-1:0] SYNC_WORD = DEF_SYNC_WORD,
  localparam int unsigned LANE_W = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [LANE_W-1:0] lane,
  input  logic              group_close,
  input  logic              stream_open,
  output logic              hit,
  output logic              found_q
);

  logic [GROUP_BYTES-1:0] lane_ok;

  for (genvar g = 0; g < GROUP_BYTES - 1; g++) begin : g_cap
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q <= '0;
      else if (in_valid && (int'(lane) == g))
        byte_q <= in_data;
    end
    assign lane_ok[g] =
      (byte_q == SYNC_WORD[lane_shift(g, GROUP_BYTES, BYTE_W) +: BYTE_W]);
  end

  assign lane_ok[GROUP_BYTES-1] = (in_data == SYNC_WORD[BYTE_W-1:0]);
  assign hit = group_close && (&lane_ok);

  always_ff @(posedge clk) begin
    if (!rst_n)
      found_q <= 1'b0;
    else if (hit)
      found_q <= 1'b1;
    else if (stream_open)
      found_q <= 1'b0;
  end

  assert_rise_on_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found_q) |-> $past(group_close));

  assert_fall_on_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(found_q) |-> $past(stream_open));

endmodule

// File: rtl/sync_det_end.sv
`timescale 1ns/1ps
module sync_det_end (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic stream_open,
  input  logic tail_ragged,
  output logic done_q,
  output logic align_q
);

  logic finish;
  assign finish = in_valid && in_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      align_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish)
        align_q <= tail_ragged;
      else if (stream_open)
        align_q <= 1'b0;
    end
  end

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(in_valid && in_last));

  assert_align_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_q) |-> done_q);

endmodule

// File: rtl/sync_word_detector.sv
`timescale 1ns/1ps
module sync_word_detector
  import sync_det_pkg::*;
#(
  parameter int unsigned BYTE_W      = DEF_BYTE_W,
  parameter int unsigned GROUP_BYTES = DEF_GROUP_BYTES,
  parameter logic [BYTE_W*GROUP_BYTES-1:0] SYNC_WORD = DEF_SYNC_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              partial_bypass,
  output logic              found,
  output logic              done,
  output logic              align_err
);

  localparam int unsigned LANE_W = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1;

  logic [LANE_W-1:0] lane;
  logic              group_close;
  logic              stream_open;
  logic              tail_ragged;
  logic              hit;
  logic              found_q;

  sync_det_lane #(.GROUP_BYTES(GROUP_BYTES)) u_lane (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .lane(lane), .group_close(group_close), .stream_open(stream_open),
    .tail_ragged(tail_ragged)
  );

  sync_det_match #(.BYTE_W(BYTE_W), .GROUP_BYTES(GROUP_BYTES), .SYNC_WORD(SYNC_WORD)) u_match (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .lane(lane), .group_close(group_close), .stream_open(stream_open),
    .hit(hit), .found_q(found_q)
  );

  sync_det_end u_end (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .stream_open(stream_open), .tail_ragged(tail_ragged),
    .done_q(done), .align_q(align_err)
  );

  assign found = found_q | partial_bypass;

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(found_q) && !done));

  assert_open_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_open && !in_last) |=> !align_err);

endmodule

// File: tb/sync_word_detector_test.sv
`timescale 1ns/1ps
module sync_word_detector_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       partial_bypass = 1'b0;
  logic       found, done, align_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sync_word_detector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .partial_bypass(partial_bypass),
    .found(found), .done(done), .align_err(align_err)
  );

  // behavioural reference model
  byte unsigned grp[$];
  bit m_found = 0, m_done = 0, m_align = 0, m_newstream = 1;
  int m_count = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      grp.delete(); m_found = 0; m_done = 0; m_align = 0; m_newstream = 1; m_count = 0;
    end else begin
      m_done = 0;
      if (in_valid) begin
        if (m_newstream) begin
          m_found = 0; m_align = 0; m_count = 0; grp.delete();
        end
        grp.push_back(in_data);
        m_count++;
        if (grp.size() == 4) begin
          if (grp[0] == 8'h66 && grp[1] == 8'h55 && grp[2] == 8'h99 && grp[3] == 8'hAA)
            m_found = 1;
          grp.delete();
        end
        if (in_last) begin
          m_done = 1;
          m_align = (m_count % 4) != 0;
          m_newstream = 1;
        end else begin
          m_newstream = 0;
        end
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      chk("R2/R3/R4/R5/R8 found (model)", found, m_found | partial_bypass);
      chk("R6 done (model)", done, m_done);
      chk("R7 align_err (model)", align_err, m_align);
    end
  end

  task automatic send(byte unsigned d, bit last);
    @(negedge clk);
    in_valid = 1; in_data = d; in_last = last;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_data = 8'h5A; in_last = 0;
    end
  endtask

  task automatic send_word(logic [31:0] w, bit last);
    send(w[31:24], 0); send(w[23:16], 0); send(w[15:8], 0); send(w[7:0], last);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 found in reset", found, 1'b0);
    chk("R1 done in reset", done, 1'b0);
    chk("R1 align_err in reset", align_err, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 found after reset", found, 1'b0);
    chk("R1 done after reset", done, 1'b0);
    chk("R1 align_err after reset", align_err, 1'b0);

    // R2 aligned match in second group
    send_word(32'h00112233, 0);
    send(8'h66, 0); send(8'h55, 0); send(8'h99, 0);
    chk("R2 not yet found", found, 1'b0);
    send(8'hAA, 1);
    idle(1);
    chk("R2 found after 4th byte", found, 1'b1);
    chk("R6 done pulse", done, 1'b1);
    chk("R7 no align error for 8 bytes", align_err, 1'b0);
    idle(1);
    chk("R6 done one cycle only", done, 1'b0);
    chk("R8 found held while idle", found, 1'b1);

    // R8 clear on first byte of new stream; R3 straddling pattern
    send(8'h00, 0);
    idle(1);
    chk("R8 found cleared by new stream", found, 1'b0);
    send(8'h66, 0); send(8'h55, 0); send(8'h99, 0); send(8'hAA, 0);
    send(8'h00, 0); send(8'h00, 0); send(8'h00, 1);
    idle(1);
    chk("R3 straddling pattern ignored", found, 1'b0);
    chk("R7 8 bytes aligned", align_err, 1'b0);

    // R3 wrong order
    send_word(32'hAA995566, 0);
    send_word(32'h55669900 | 32'hAA, 1);
    idle(1);
    chk("R3 reordered bytes ignored", found, 1'b0);

    // R7 ragged stream with match
    send_word(32'h665599AA, 0);
    send(8'h12, 1);
    idle(1);
    chk("R7 align error on 5 bytes", align_err, 1'b1);
    chk("R2 found in ragged stream", found, 1'b1);
    idle(2);
    chk("R7 align error held", align_err, 1'b1);

    // R4 trailing partial group not joined with next stream
    send(8'h66, 0); send(8'h55, 0); send(8'h99, 1);
    idle(1);
    chk("R4 partial tail not matched", found, 1'b0);
    chk("R7 align error on 3 bytes", align_err, 1'b1);
    send(8'hAA, 0);
    idle(1);
    chk("R7 align cleared at stream start", align_err, 1'b0);
    chk("R4 tail not joined across streams", found, 1'b0);
    send(8'h01, 0); send(8'h02, 0); send(8'h03, 1);
    idle(1);
    chk("R4 no match in shifted stream", found, 1'b0);

    // R9 gaps and ignored last while invalid
    send(8'h66, 0);
    @(negedge clk); in_valid = 0; in_last = 1; in_data = 8'hAA;
    @(negedge clk); in_valid = 0; in_last = 1; in_data = 8'h00;
    chk("R9 invalid last gives no done", done, 1'b0);
    send(8'h55, 0); idle(2); send(8'h99, 0); idle(1); send(8'hAA, 1);
    idle(1);
    chk("R9 match across idle gaps", found, 1'b1);
    chk("R9 stream length counts valid bytes only", align_err, 1'b0);

    // R5 bypass
    send_word(32'h01020304, 0);
    partial_bypass = 1;
    #1;
    chk("R5 bypass forces found", found, 1'b1);
    send_word(32'h05060708, 1);
    idle(1);
    chk("R5 bypass through end", found, 1'b1);
    partial_bypass = 0;
    #1;
    chk("R5 bypass released", found, 1'b0);

    // random streams with planted words (model compare every clock)
    for (int s = 0; s < 60; s++) begin
      int len = 1 + ($urandom % 40);
      for (int b = 0; b < len; b++) begin
        byte unsigned d;
        case ($urandom % 6)
          0: d = 8'h66; 1: d = 8'h55; 2: d = 8'h99; 3: d = 8'hAA;
          default: d = byte'($urandom);
        endcase
        if ((b % 4 == 0) && (b + 4 <= len) && ($urandom % 8 == 0)) begin
          send(8'h66, 0); send(8'h55, 0); send(8'h99, 0); send(8'hAA, (b + 4 == len));
          b += 3;
        end else begin
          send(d, (b == len - 1));
        end
        if ($urandom % 5 == 0) idle(1);
      end
      idle(1 + ($urandom % 3));
    end

    idle(3);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule